// File: doc/BRIEF.md
# Prioritized Address Window Decoder

This block decides which target interface an incoming transaction address belongs to. It holds eight programmable windows. Each window has a base address, a power-of-two size code, an enable bit and a target identifier. For the address on its input, the lookup is combinational. It returns a hit flag, the target code and the index of the window that won. The address itself is not altered; only the routing decision leaves the block.

Windows may overlap. When they do, the lowest-numbered enabled window that covers the address wins. A simple word-addressed write/read port programs the windows, and every register reads back what was last written to it, so software can confirm a setting before traffic uses it. Window 0 leaves reset preconfigured as an 8-Mbyte window at address zero. Its enable comes from a boot-location strap that is sampled while reset is asserted.

Top module: `addr_win_decoder`

## Requirements
- R1: When several enabled windows cover the address, `hit_o` is 1 and `win_idx_o`/`target_o` come from the lowest-numbered one.
- R2: A window with size code S spans 2^(S+1) bytes. It matches when address bits [31:S+1] equal the same bits of its base, and base bits below that boundary have no effect.
- R3: A window whose enable bit is 0, or whose size code is below 11, never matches.
- R4: When no window matches, `hit_o` is 0, `target_o` is 4'hF and `win_idx_o` is 0.
- R5: After reset, window 0 has base 0, target 0 and size code 22. Its enable equals the value of `boot_ddr_i` during reset.
- R6: After reset, windows 1 to 7 read back all zero and are disabled.
- R7: Register map: `reg_addr_i[3:1]` selects the window. `reg_addr_i[0]`=0 selects the base register, which stores bits [31:12] and reads bits [11:0] as zero. `reg_addr_i[0]`=1 selects the attribute register, laid out as bit 31 enable, bits [23:20] target and bits [5:0] size code; all other bits read as zero. A read returns the value last written, under that mask.
- R8: A write takes effect at the rising clock edge where `reg_we_i` is sampled high. Before that edge the lookup still uses the old setting. The lookup follows `addr_i` in the same cycle, with no clock in between.
- R9: Size codes of 31 and above cover the whole 32-bit address space, whatever the base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| boot_ddr_i | input | 1 | Boot-location strap; sets window 0's reset enable |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register word address (window index, base/attribute select) |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for `reg_addr_i`, combinational |
| addr_i | input | 32 | Transaction address to decode |
| hit_o | output | 1 | An enabled window covers `addr_i` |
| target_o | output | 4 | Selected target code, 4'hF on a miss |
| win_idx_o | output | 3 | Index of the winning window, 0 on a miss |

## Verification
The lookup outputs and read data depend only on their inputs within the cycle. The bench therefore changes `addr_i` or `reg_addr_i` between clock edges and samples 1 ns later, with no edge in between. A register write is due one edge after the strobe is driven. The bench drives the write just after a falling edge and checks the lookup once before the next rising edge, where it must still show the old setting. It checks again 1 ns after that rising edge, where the new setting must have taken effect. Reset values are read back through the register port after reset is released, with the strap held at each value in turn.

// File: rtl/awd_pkg.sv
package awd_pkg;
  localparam int ADDR_W   = 32;
  localparam int DATA_W   = 32;
  localparam int BASE_LSB = 12;
  localparam int BASE_W   = ADDR_W - BASE_LSB;
  localparam int TGT_W    = 4;
  localparam int SIZE_W   = 6;
  localparam int EN_BIT   = 31;
  localparam int TGT_LSB  = 20;

  localparam logic [DATA_W-1:0] BASE_MASK = {{BASE_W{1'b1}}, {BASE_LSB{1'b0}}};
  localparam logic [DATA_W-1:0] ATTR_MASK =
      (DATA_W'(1) << EN_BIT) | (DATA_W'({TGT_W{1'b1}}) << TGT_LSB) | DATA_W'({SIZE_W{1'b1}});

  typedef struct packed {
    logic              en;
    logic [TGT_W-1:0]  tgt;
    logic [SIZE_W-1:0] size;
    logic [BASE_W-1:0] base;
  } win_cfg_t;
endpackage

// File: rtl/awd_regfile.sv
module awd_regfile
  import awd_pkg::*;
#(
  parameter int NUM_WIN = 8,
  parameter int W0_SIZE = 22,
  parameter int W0_TGT  = 0,
  localparam int IDX_W  = $clog2(NUM_WIN),
  localparam int RA_W   = IDX_W + 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    boot_ddr_i,
  input  logic                    reg_we_i,
  input  logic [RA_W-1:0]         reg_addr_i,
  input  logic [DATA_W-1:0]       reg_wdata_i,
  output logic [DATA_W-1:0]       reg_rdata_o,
  output win_cfg_t [NUM_WIN-1:0]  win_o
);

  logic [IDX_W-1:0] sel_idx;
  logic             sel_attr;

  assign sel_idx  = reg_addr_i[RA_W-1:1];
  assign sel_attr = reg_addr_i[0];

  for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
    logic hit_w;
    assign hit_w = reg_we_i && (int'(sel_idx) == g);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        if (g == 0) begin
          win_o[g].en   <= boot_ddr_i;
          win_o[g].tgt  <= TGT_W'(W0_TGT);
          win_o[g].size <= SIZE_W'(W0_SIZE);
          win_o[g].base <= '0;
        end else begin
          win_o[g] <= '0;
        end
      end else if (hit_w) begin
        if (sel_attr) begin
          win_o[g].en   <= reg_wdata_i[EN_BIT];
          win_o[g].tgt  <= reg_wdata_i[TGT_LSB +: TGT_W];
          win_o[g].size <= reg_wdata_i[SIZE_W-1:0];
        end else begin
          win_o[g].base <= reg_wdata_i[DATA_W-1:BASE_LSB];
        end
      end
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    if (int'(sel_idx) < NUM_WIN) begin
      if (sel_attr) begin
        reg_rdata_o[EN_BIT]              = win_o[sel_idx].en;
        reg_rdata_o[TGT_LSB +: TGT_W]    = win_o[sel_idx].tgt;
        reg_rdata_o[SIZE_W-1:0]          = win_o[sel_idx].size;
      end else begin
        reg_rdata_o[DATA_W-1:BASE_LSB]   = win_o[sel_idx].base;
      end
    end
  end

  AST_BASE_READBACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(reg_we_i) && !$past(reg_addr_i[0]) && reg_addr_i == $past(reg_addr_i))
      |-> reg_rdata_o == ($past(reg_wdata_i) & BASE_MASK)); // R7

  AST_ATTR_READBACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(reg_we_i) && $past(reg_addr_i[0]) && reg_addr_i == $past(reg_addr_i))
      |-> reg_rdata_o == ($past(reg_wdata_i) & ATTR_MASK)); // R7

endmodule

// File: rtl/awd_match.sv
module awd_match
  import awd_pkg::*;
#(
  parameter int MIN_SIZE = 11
) (
  input  win_cfg_t          cfg_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              match_o
);

  logic [ADDR_W-1:0] keep;
  logic [ADDR_W-1:0] base_full;
  logic              valid;

  assign base_full = {cfg_i.base, {BASE_LSB{1'b0}}};
  assign valid     = cfg_i.en && (int'(cfg_i.size) >= MIN_SIZE);

  // keep bits at or above the size boundary (bit size+1)
  always_comb begin
    for (int b = 0; b < ADDR_W; b++) begin
      keep[b] = (b > int'(cfg_i.size));
    end
  end

  assign match_o = valid && (((addr_i ^ base_full) & keep) == '0);

endmodule

// File: rtl/awd_prio.sv
module awd_prio #(
  parameter int NUM_WIN = 8,
  localparam int IDX_W  = $clog2(NUM_WIN)
) (
  input  logic [NUM_WIN-1:0] match_i,
  output logic               hit_o,
  output logic [IDX_W-1:0]   idx_o
);

  always_comb begin
    idx_o = '0;
    for (int i = NUM_WIN - 1; i >= 0; i--) begin
      if (match_i[i]) idx_o = IDX_W'(i);
    end
  end

  assign hit_o = |match_i;

endmodule

// File: rtl/addr_win_decoder.sv
module addr_win_decoder
  import awd_pkg::*;
#(
  parameter int NUM_WIN     = 8,
  parameter int MIN_SIZE    = 11,
  parameter int W0_SIZE     = 22,
  parameter int W0_TGT      = 0,
  parameter int DEFAULT_TGT = 15,
  localparam int IDX_W      = $clog2(NUM_WIN),
  localparam int RA_W       = IDX_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              boot_ddr_i,
  input  logic              reg_we_i,
  input  logic [RA_W-1:0]   reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o,
  output logic [TGT_W-1:0]  target_o,
  output logic [IDX_W-1:0]  win_idx_o
);

  win_cfg_t [NUM_WIN-1:0] win_cfg;
  logic     [NUM_WIN-1:0] match_w;
  logic                   any_hit;
  logic     [IDX_W-1:0]   win_idx;

  awd_regfile #(
    .NUM_WIN (NUM_WIN),
    .W0_SIZE (W0_SIZE),
    .W0_TGT  (W0_TGT)
  ) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .boot_ddr_i  (boot_ddr_i),
    .reg_we_i    (reg_we_i),
    .reg_addr_i  (reg_addr_i),
    .reg_wdata_i (reg_wdata_i),
    .reg_rdata_o (reg_rdata_o),
    .win_o       (win_cfg)
  );

  for (genvar g = 0; g < NUM_WIN; g++) begin : g_match
    awd_match #(.MIN_SIZE(MIN_SIZE)) u_match (
      .cfg_i   (win_cfg[g]),
      .addr_i  (addr_i),
      .match_o (match_w[g])
    );

    AST_OFF_NO_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!win_cfg[g].en || int'(win_cfg[g].size) < MIN_SIZE) |-> !match_w[g]); // R3
  end

  awd_prio #(.NUM_WIN(NUM_WIN)) u_prio (
    .match_i (match_w),
    .hit_o   (any_hit),
    .idx_o   (win_idx)
  );

  assign hit_o     = any_hit;
  assign win_idx_o = win_idx;
  assign target_o  = any_hit ? win_cfg[win_idx].tgt : TGT_W'(DEFAULT_TGT);

  logic [NUM_WIN-1:0] lower_mask;
  assign lower_mask = (NUM_WIN'(1) << win_idx_o) - NUM_WIN'(1);

  AST_LOWEST_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> (match_w & lower_mask) == '0); // R1

  AST_WINNER_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> (match_w[win_idx_o] && target_o == win_cfg[win_idx_o].tgt)); // R1

  AST_MISS_DEFAULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |-> (target_o == TGT_W'(DEFAULT_TGT) && win_idx_o == '0 && match_w == '0)); // R4

endmodule

// File: tb/sim_addr_win_decoder.sv
`timescale 1ns/1ps
module sim_addr_win_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        boot_ddr = 1'b0;
  logic        we = 1'b0;
  logic [3:0]  raddr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [31:0] addr = '0;
  logic        hit;
  logic [3:0]  tgt;
  logic [2:0]  idx;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  addr_win_decoder u0 (
    .clk_i(clk), .rst_ni(rst_n), .boot_ddr_i(boot_ddr),
    .reg_we_i(we), .reg_addr_i(raddr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .addr_i(addr), .hit_o(hit), .target_o(tgt), .win_idx_o(idx)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic look(input string tag, input logic [31:0] a,
                      input logic eh, input logic [3:0] et, input logic [2:0] ei);
    addr = a;
    #1;
    chk(tag, {23'b0, hit, tgt, idx}, {23'b0, eh, et, ei});
  endtask

  task automatic rd(input string tag, input logic [3:0] ra, input logic [31:0] exp);
    raddr = ra;
    #1;
    chk(tag, rdata, exp);
  endtask

  task automatic wr(input logic [3:0] ra, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; raddr = ra; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic do_reset(input logic strap);
    @(negedge clk);
    rst_n = 1'b0; boot_ddr = strap;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset_nodd();
    do_reset(1'b0);
    rd("R5 attr0 strap low", 4'd1, 32'h0000_0016);
    rd("R5 base0", 4'd0, 32'h0);
    look("R5 w0 off miss", 32'h0000_0000, 1'b0, 4'hF, 3'd0);
  endtask

  task automatic t_reset_ddr();
    do_reset(1'b1);
    rd("R5 attr0 strap high", 4'd1, 32'h8000_0016);
    for (int w = 1; w < 8; w++) begin
      rd("R6 attr reset", 4'(2*w+1), 32'h0);
      rd("R6 base reset", 4'(2*w), 32'h0);
    end
    look("R5 w0 hit", 32'h0012_3456, 1'b1, 4'h0, 3'd0);
    look("R2 w0 top", 32'h007F_FFFF, 1'b1, 4'h0, 3'd0);
    look("R4 past 8MB", 32'h0080_0000, 1'b0, 4'hF, 3'd0);
  endtask

  task automatic t_timing();
    wr(4'd6, 32'h3000_0000);
    @(negedge clk);
    we = 1'b1; raddr = 4'd7; wdata = 32'h8020_0013;
    addr = 32'h3000_0000;
    #1;
    chk("R8 before edge", {28'b0, hit, idx}, {28'b0, 1'b0, 3'd0});
    @(posedge clk);
    #1;
    we = 1'b0;
    chk("R8 after edge", {23'b0, hit, tgt, idx}, {23'b0, 1'b1, 4'h2, 3'd3});
    @(negedge clk);
  endtask

  task automatic t_overlap();
    wr(4'd2, 32'h7FF0_0000);
    wr(4'd3, 32'h8010_0013);
    wr(4'd14, 32'h0000_0000);
    wr(4'd15, 32'h8000_001E);
    rd("R7 attr1", 4'd3, 32'h8010_0013);
    rd("R7 base1", 4'd2, 32'h7FF0_0000);
    look("R1 low end", 32'h7FF0_0000, 1'b1, 4'h1, 3'd1);
    look("R1 high end", 32'h7FFF_FFFF, 1'b1, 4'h1, 3'd1);
    look("R2 below w1", 32'h7FEF_FFFF, 1'b1, 4'h0, 3'd7);
    look("R2 ddr route", 32'h1000_0000, 1'b1, 4'h0, 3'd7);
    look("R4 above 2GB", 32'h8000_0000, 1'b0, 4'hF, 3'd0);
    look("R1 w0 over w7", 32'h0000_0100, 1'b1, 4'h0, 3'd0);
  endtask

  task automatic t_prio();
    wr(4'd4, 32'h1000_0000);
    wr(4'd5, 32'h8030_001B);
    look("R1 w2 over w7", 32'h1ABC_DEF0, 1'b1, 4'h3, 3'd2);
    wr(4'd6, 32'h1000_0000);
    wr(4'd7, 32'h8020_001B);
    look("R1 w2 over w3", 32'h1ABC_DEF0, 1'b1, 4'h3, 3'd2);
    wr(4'd5, 32'h0030_001B);
    rd("R7 attr2 disabled", 4'd5, 32'h0030_001B);
    look("R3 disabled w2", 32'h1ABC_DEF0, 1'b1, 4'h2, 3'd3);
  endtask

  task automatic t_base_low();
    wr(4'd8, 32'h2034_5FFF);
    rd("R7 base mask", 4'd8, 32'h2034_5000);
    wr(4'd9, 32'h8050_0013);
    look("R2 base low ignored", 32'h2030_0000, 1'b1, 4'h5, 3'd4);
    look("R2 w4 top", 32'h203F_FFFF, 1'b1, 4'h5, 3'd4);
    look("R2 w4 past", 32'h2040_0000, 1'b1, 4'h0, 3'd7);
  endtask

  task automatic t_small();
    wr(4'd10, 32'h4000_0000);
    wr(4'd11, 32'h8060_000A);
    look("R3 size 10 ignored", 32'h4000_0000, 1'b1, 4'h0, 3'd7);
    wr(4'd11, 32'h8060_000B);
    look("R3 size 11 4KB", 32'h4000_0FFF, 1'b1, 4'h6, 3'd5);
    look("R2 4KB past", 32'h4000_1000, 1'b1, 4'h0, 3'd7);
  endtask

  task automatic t_full();
    wr(4'd12, 32'h1234_5000);
    wr(4'd13, 32'h8070_001F);
    look("R9 size 31", 32'hFFFF_FFF0, 1'b1, 4'h7, 3'd6);
    look("R1 w3 over w6", 32'h1000_0000, 1'b1, 4'h2, 3'd3);
    wr(4'd13, 32'h8070_003F);
    look("R9 size 63", 32'hC000_0000, 1'b1, 4'h7, 3'd6);
    wr(4'd1, 32'hFFFF_FFFF);
    rd("R7 attr mask", 4'd1, 32'h80F0_003F);
    look("R9 w0 full", 32'h8000_0000, 1'b1, 4'hF, 3'd0);
  endtask

  initial begin
    t_reset_nodd();
    t_reset_ddr();
    t_timing();
    t_overlap();
    t_prio();
    t_base_low();
    t_small();
    t_full();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule